// File: doc/BRIEF.md
# Two-Wire Serial Byte Store Target

This block is a target on a two-wire serial bus (I2C / SMBus signalling) that holds a 256-byte array behind one 8-bit current-location pointer. It samples the clock and data lines through synchronizers and recognises start, repeated start and stop conditions. It answers one configurable 7-bit address. It drives the data line open-drain, pulling it low only, for acknowledge bits and for read data.

A controller sets the pointer by writing a single byte. It fills consecutive locations by writing a start location followed by data. It reads the byte at the pointer, and the pointer then advances. A combined sequence (write one location byte, repeated start, then read) reads from a chosen location. There is no length byte in any block transfer. A separate preload port lets a test environment fill the array directly. Several instances at neighbouring addresses (default 0x50; the range 0x50 to 0x57 is typical) each own their own array.

Top module: `eep_target`

## Requirements
- R1: After reset the current-location pointer is 0 and the target is not pulling the data line low.
- R2: The target pulls the data line low during the acknowledge bit after an address byte whose upper 7 bits equal DEV_ADDR, and after every byte written to it. For any other address it never drives the line, and data bytes that follow in that transaction change no location.
- R3: A quick command (start, address byte with the write bit 0 acknowledged, stop) changes neither the array nor the pointer.
- R4: A write transaction with exactly one data byte loads that byte into the pointer and stores nothing.
- R5: In a write transaction with two or more data bytes, the first byte names a start location and each later byte is stored at the next location in turn.
- R6: When a multi-byte write passes location 255, the following bytes are stored from location 0 onward.
- R7: A multi-byte write leaves the pointer unchanged.
- R8: Each byte read returns the array at the pointer, and the pointer then advances by one, wrapping from 255 to 0. The address byte has bit 0 set to 1 for a read, and data is sent most significant bit first.
- R9: In a write of one location byte followed by a repeated start and a read, the first byte read comes from that location. Later bytes, including those of later read-only transactions, continue from there.
- R10: When the controller answers a read byte with a not-acknowledge (data line high), the target releases the data line and drives nothing more until the next start.
- R11: The data-line drive changes only while the synchronized clock line is low.
- R12: A one-cycle pulse on pre_we writes pre_data to location pre_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | PTR_W (8) | Preload location |
| pre_data | input | DATA_W (8) | Preload byte |

## Verification
Both lines pass two synchronizer flops and one edge register. The target therefore changes sda_oe on the third clock after the clock line falls, and it samples data on the third clock after the line rises. The bench holds each clock phase for ten system clocks. It changes its own data drive three clocks after each falling edge and samples the shared data line halfway through the high phase. This sampling point is always several cycles after the target's drive has settled. Array contents and the pointer are observed only through later read transactions. Each expected byte comes from a bench-side model of the array and pointer that follows the write and read rules above.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_RACK
  } st_t;

  // Header byte matches when its upper seven bits equal the device address.
  function automatic logic addr_hit(input logic [7:0] hdr, input logic [6:0] own);
    return hdr[7:1] == own;
  endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_din,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (pre_we)      arr[pre_addr] <= pre_din;
    else if (bus_we) arr[bus_addr] <= bus_din;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/eep_target.sv
module eep_target
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         PTR_W       = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pre_we,
  input  logic [PTR_W-1:0]  pre_addr,
  input  logic [DATA_W-1:0] pre_data
);
  localparam int                CNT_W   = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_TX = CNT_W'(DATA_W - 1);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // Synchronized lines and bus events
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, ev_start, ev_stop;

  eep_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  // Protocol state
  st_t                state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  rx_sh;
  logic [DATA_W-2:0]  tx_sh;
  logic               rw_rd, nack_q, oe_q;
  logic [PTR_W-1:0]   ptr, cmd_q, wr_addr;
  logic [1:0]         wcnt;
  logic [DATA_W-1:0]  rd_byte;

  // Named internal events
  logic byte_done, wr_stb, ptr_commit, rd_load;
  assign byte_done  = (state == ST_WR) && scl_fall && (bit_cnt == FULL);
  assign wr_stb     = byte_done && (wcnt != 2'd0);
  assign ptr_commit = (ev_start || ev_stop) && (wcnt == 2'd1);
  assign rd_load    = scl_fall && (((state == ST_ACK_A) && rw_rd) ||
                                   ((state == ST_RACK) && !nack_q));

  eep_mem #(.AW(PTR_W), .DW(DATA_W)) u_mem (
    .clk(clk),
    .bus_we(wr_stb), .bus_addr(wr_addr), .bus_din(rx_sh),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_din(pre_data),
    .raddr(ptr), .rdata(rd_byte)
  );

  // Pointer, location byte and write bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      cmd_q   <= '0;
      wr_addr <= '0;
      wcnt    <= 2'd0;
    end else begin
      if (ptr_commit)   ptr <= cmd_q;
      else if (rd_load) ptr <= step(ptr);

      if (ev_start || ev_stop) begin
        wcnt <= 2'd0;
      end else if (byte_done) begin
        if (wcnt == 2'd0) begin
          cmd_q   <= rx_sh[PTR_W-1:0];
          wr_addr <= rx_sh[PTR_W-1:0];
        end else begin
          wr_addr <= step(wr_addr);
        end
        if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
      end
    end
  end

  // Bit-level sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rw_rd   <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (ev_start) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (ev_stop) begin
      state   <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == FULL) begin
            bit_cnt <= '0;
            if (state == ST_WR) begin
              oe_q  <= 1'b1;
              state <= ST_ACK_W;
            end else if (addr_hit(rx_sh[7:0], DEV_ADDR)) begin
              rw_rd <= rx_sh[0];
              oe_q  <= 1'b1;
              state <= ST_ACK_A;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_rd) begin
              tx_sh <= rd_byte[DATA_W-2:0];
              oe_q  <= ~rd_byte[DATA_W-1];
              state <= ST_RD;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_WR;
            end
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_TX) begin
              oe_q  <= 1'b0;
              state <= ST_RACK;
            end else begin
              oe_q    <= ~tx_sh[DATA_W-2];
              tx_sh   <= {tx_sh[DATA_W-3:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state <= ST_IDLE;
            end else begin
              bit_cnt <= '0;
              tx_sh   <= rd_byte[DATA_W-2:0];
              oe_q    <= ~rd_byte[DATA_W-1];
              state   <= ST_RD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/eep_target_chk.sv
module eep_target_chk
  import eep_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input st_t              state,
  input logic [PTR_W-1:0] ptr,
  input logic             rd_load,
  input logic             ptr_commit
);

  // R11: drive changes only while the synchronized clock is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R8: a read load advances the pointer by one
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_load && !ptr_commit) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R7: the pointer moves only on a read load or a single-byte commit
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(rd_load || ptr_commit));

  // R10: no drive while idle (after a not-acknowledge or foreign address)
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: acknowledge slots always pull the line low
  a_r2_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACK_A) || (state == ST_ACK_W)) |-> sda_oe);

endmodule

bind eep_target eep_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .state(state), .ptr(ptr), .rd_load(rd_load), .ptr_commit(ptr_commit)
);

// File: tb/tb_eep_target.sv
module tb_eep_target;
  localparam logic [6:0] OWN = 7'h50;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_c = 1'b1, sda_c = 1'b1;
  logic pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  logic sda_oe;
  wire  sda_ln = sda_c & ~sda_oe;

  always #10 clk = ~clk;  // 50 MHz

  eep_target #(.DEV_ADDR(OWN)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_ln), .sda_oe(sda_oe),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  int checks = 0, errors = 0, viol = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [260];
  int eptr = 0;
  logic oe_prev = 1'b0;

  // R11 monitor: drive must not change while the clock line is high
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_c) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; hold(H); scl_c = 1'b1; hold(H);
    sda_c = 1'b0; hold(H); scl_c = 1'b0; hold(3);
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; hold(H); scl_c = 1'b1; hold(H); sda_c = 1'b1; hold(H);
  endtask

  task automatic put_bit(input logic b);
    hold(3); sda_c = b; hold(H - 3); scl_c = 1'b1; hold(H); scl_c = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    hold(3); sda_c = 1'b1; hold(H - 3); scl_c = 1'b1;
    hold(H / 2); b = sda_ln; hold(H / 2); scl_c = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  task automatic wr_txn(input logic [6:0] a, input int n, output int acks);
    bit k;
    acks = 0;
    bus_start();
    put_byte({a, 1'b0}, k); acks += int'(k);
    for (int i = 0; i < n; i++) begin put_byte(wbuf[i], k); acks += int'(k); end
    bus_stop();
  endtask

  task automatic rd_txn(input bit with_cmd, input logic [7:0] cmd, input int n);
    bit k;
    bus_start();
    if (with_cmd) begin
      put_byte({OWN, 1'b0}, k); put_byte(cmd, k); bus_start();
    end
    put_byte({OWN, 1'b1}, k);
    for (int i = 0; i < n; i++) get_byte(i == n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic model_write(input int n);
    if (n >= 2)
      for (int k = 1; k < n; k++) model[8'(int'(wbuf[0]) + k - 1)] = wbuf[k];
  endtask

  task automatic cmp_reads(input string r, input int start, input int n);
    for (int i = 0; i < n; i++) chk(r, rbuf[i], model[8'(start + i)]);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int acks;
    logic b;
    hold(5);
    rst_n = 1'b1;
    hold(3);
    chk("R1 line released", sda_ln, 1);

    // R12: preload every location
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'(i * 73 + 29);
      pre_we = 1'b1; pre_addr = 8'(i); pre_data = model[i];
      hold(1);
    end
    pre_we = 1'b0;
    hold(2);

    // R1: first read comes from location 0
    rd_txn(0, 8'h00, 1);
    chk("R1 pointer zero", rbuf[0], model[0]);
    eptr = 1;

    // R8/R12: full sweep, wraps past 255
    rd_txn(0, 8'h00, 256);
    cmp_reads("R8 R12 sweep", eptr, 256);
    eptr = 8'(eptr + 256);

    // R2: foreign address ignored, nothing stored
    wbuf[0] = 8'h05; wbuf[1] = 8'hAA; wbuf[2] = 8'hBB;
    wr_txn(7'h51, 3, acks);
    chk("R2 foreign no ack", acks, 0);

    // R4: single data byte loads pointer
    wbuf[0] = 8'h10;
    wr_txn(OWN, 1, acks);
    chk("R2 R4 acks", acks, 2);
    eptr = 8'h10;
    rd_txn(0, 8'h00, 2);
    cmp_reads("R4 pointer load", eptr, 2);
    eptr += 2;

    // R3: quick command
    wr_txn(OWN, 0, acks);
    chk("R3 quick ack", acks, 1);
    rd_txn(0, 8'h00, 1);
    cmp_reads("R3 quick no change", eptr, 1);
    eptr += 1;

    // R5/R7: multi-byte write
    wbuf[0] = 8'h80; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
    wr_txn(OWN, 4, acks);
    chk("R2 R5 acks", acks, 5);
    model_write(4);
    rd_txn(0, 8'h00, 1);
    cmp_reads("R7 pointer kept", eptr, 1);
    rd_txn(1, 8'h7F, 5);
    cmp_reads("R5 R9 consecutive", 8'h7F, 5);

    // R6: write wraps past 255
    wbuf[0] = 8'hFE; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2; wbuf[3] = 8'hC3; wbuf[4] = 8'hC4;
    wr_txn(OWN, 5, acks);
    model_write(5);
    rd_txn(1, 8'hFD, 6);
    cmp_reads("R6 write wrap", 8'hFD, 6);

    // R9 / R2: combined read where foreign write aimed; continuation
    rd_txn(1, 8'h05, 2);
    cmp_reads("R9 R2 combined", 8'h05, 2);
    rd_txn(0, 8'h00, 1);
    chk("R9 continuation", rbuf[0], model[8'h07]);

    // R10: not-acknowledge ends the read
    bus_start();
    begin bit k; put_byte({OWN, 1'b1}, k); end
    get_byte(1'b1, rbuf[0]);
    chk("R10 nack byte", rbuf[0], model[8'h08]);
    get_bit(b); chk("R10 released bit a", b, 1);
    get_bit(b); chk("R10 released bit b", b, 1);
    bus_stop();
    rd_txn(0, 8'h00, 1);
    chk("R10 next read", rbuf[0], model[8'h09]);

    chk("R11 drive during clock low", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule